// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of an 8-bit accumulator machine. On each cycle where the enable is high, it takes an operation code, the current accumulator, one operand byte and the current five-bit flag word. It then registers a result byte and a new flag word. The surrounding core fetches the operand, decodes instructions and writes the result back. None of that work is done here.

Each operation follows its own rule for which flags it updates. Add and subtract style operations rewrite every flag. Increment and decrement act on the operand byte and never touch carry. Compare keeps the accumulator value as its result. Rotates change only carry. Complement-accumulator leaves every flag alone. Decimal adjust uses the incoming auxiliary carry and carry to correct a packed BCD sum.

Flag word layout, used on both `flags_in` and `flags_out`: bit 0 carry (C), bit 1 parity (P), bit 2 auxiliary carry (AC), bit 3 zero (Z), bit 4 sign (S).

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `res_out`, `flags_out` and `res_vld` are cleared to zero on that edge.
- R2: With `en` high at a rising edge, the result and flags of that cycle's inputs appear after that edge and `res_vld` is 1 for that cycle. While `en` is low, `res_out` and `flags_out` hold and `res_vld` is 0.
- R3: Op 0 (add) and op 1 (add with carry, which also adds `flags_in` bit 0) produce acc+opnd[+C]. C is the carry out of bit 7 and AC is the carry out of bit 3.
- R4: Op 2 (subtract) and op 3 (subtract with borrow, which also subtracts C) produce acc-opnd[-C]. C is 1 when the operand plus borrow-in exceeds the accumulator as unsigned numbers. AC is 1 on a borrow into bit 4.
- R5: Op 7 (compare) sets C, AC, Z, S and P exactly as op 2 would. Its result byte equals `acc_in`.
- R6: Op 8 (increment) and op 9 (decrement) produce opnd+1 and opnd-1. They update Z, S, P and AC: AC is set on a carry out of bit 3 for increment and a borrow into bit 4 for decrement. C passes through unchanged.
- R7: Op 4 (AND) produces acc&opnd, clears C, and sets AC to the OR of bit 3 of the two inputs.
- R8: Op 5 (XOR) and op 6 (OR) produce acc^opnd and acc|opnd, and clear both C and AC.
- R9: For every operation that updates Z, S and P, Z is 1 when the flagged value is zero. S equals its bit 7. P is 1 when it holds an even number of one bits.
- R10: Op 10 rotates the accumulator left circularly and op 11 rotates it right circularly; in both, C receives the bit moved across the end. Op 12 rotates left and op 13 rotates right through carry as a ninth bit. Rotates leave S, Z, AC and P unchanged.
- R11: Op 14 inverts all accumulator bits and leaves all flags unchanged. Op 15 inverts C and op 16 sets C to 1. Both pass the accumulator through and leave the other flags unchanged.
- R12: Op 17 (decimal adjust) adds 0x06 when the low nibble is above 9 or AC is set. It then adds 0x60 when the intermediate value is above 0x9F or C is set. C becomes 1 exactly when that second step applies, AC is the carry out of bit 3 of the first step, and Z, S and P follow R9.
- R13: Op codes 18 to 31 pass `acc_in` and `flags_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Capture this cycle's result |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Current accumulator |
| opnd | input | 8 | Operand byte |
| flags_in | input | 5 | Current flags {S,Z,AC,P,C} |
| res_out | output | 8 | Registered result byte |
| flags_out | output | 5 | Registered flags {S,Z,AC,P,C} |
| res_vld | output | 1 | A result was captured on the last edge |

## Verification
Two pairs of effects can land in one operation. Decimal adjust can apply both its low-nibble and high-nibble corrections at once, for example on 0x9B, where the first step pushes the high nibble past 9. Add with carry can ripple the incoming carry across both the nibble and the byte boundary, as in 0xFF + 0x00 + 1. Both cases are driven on purpose, along with a sweep of every op code over edge-pattern bytes. Each registered result is compared against a reference model built from the requirements, in a scoreboard fed back to back.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_CMC = 5'd15,
    OP_STC = 5'd16, OP_DAA = 5'd17
  } alu_op_e;

  localparam int FLW = 5;
  localparam int FC  = 0;
  localparam int FP  = 1;
  localparam int FA  = 2;
  localparam int FZ  = 3;
  localparam int FS  = 4;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          hcout
);
  localparam int NW = DW / 2;

  logic [DW:0] full;
  logic [NW:0] half;

  always_comb begin
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
      half = {1'b0, x[NW-1:0]} - {1'b0, y[NW-1:0]} - {{NW{1'b0}}, cin};
    end else begin
      full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
      half = {1'b0, x[NW-1:0]} + {1'b0, y[NW-1:0]} + {{NW{1'b0}}, cin};
    end
  end

  assign sum   = full[DW-1:0];
  assign cout  = full[DW];
  assign hcout = half[NW];
endmodule

// File: rtl/alu_rotdaa.sv
module alu_rotdaa #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          cin,
  input  logic          acin,
  input  logic [1:0]    rmode,
  output logic [DW-1:0] rot_res,
  output logic          rot_c,
  output logic [DW-1:0] daa_res,
  output logic          daa_c,
  output logic          daa_ac
);
  localparam int NW = DW / 2;
  localparam logic [NW-1:0] NIB_MAX = NW'(9);
  localparam logic [NW:0]   LO_ADJ  = (NW+1)'(6);
  localparam logic [DW:0]   BYTE_LO = (DW+1)'(6);
  localparam logic [DW:0]   BYTE_HI = BYTE_LO << NW;

  // rotate unit: mode 0 left circular, 1 right circular, 2 left via C, 3 right via C
  always_comb begin
    unique case (rmode)
      2'd0: begin rot_res = {a[DW-2:0], a[DW-1]}; rot_c = a[DW-1]; end
      2'd1: begin rot_res = {a[0], a[DW-1:1]};    rot_c = a[0];    end
      2'd2: begin rot_res = {a[DW-2:0], cin};     rot_c = a[DW-1]; end
      default: begin rot_res = {cin, a[DW-1:1]};  rot_c = a[0];    end
    endcase
  end

  // decimal adjust: low correction first, high correction on the intermediate
  logic          lo_fix, hi_fix;
  logic [NW:0]   lo_sum;
  logic [DW:0]   step1;

  always_comb begin
    lo_fix  = (a[NW-1:0] > NIB_MAX) | acin;
    lo_sum  = {1'b0, a[NW-1:0]} + LO_ADJ;
    step1   = {1'b0, a} + (lo_fix ? BYTE_LO : '0);
    hi_fix  = step1[DW] | (step1[DW-1:NW] > NIB_MAX) | cin;
    daa_res = step1[DW-1:0] + (hi_fix ? BYTE_HI[DW-1:0] : '0);
    daa_c   = hi_fix;
    daa_ac  = lo_fix & lo_sum[NW];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [4:0]    op,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] opnd,
  input  logic [4:0]    flags_in,
  output logic [DW-1:0] res_out,
  output logic [4:0]    flags_out,
  output logic          res_vld
);
  localparam int NW = DW / 2;

  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // shared adder operand selection
  logic          on_opnd, use_cin, is_sub;
  logic [DW-1:0] ax, ay, asum;
  logic          acin, acout, ahc;

  always_comb begin
    on_opnd = (op_e == OP_INC) || (op_e == OP_DEC);
    use_cin = (op_e == OP_ADC) || (op_e == OP_SBB);
    is_sub  = (op_e == OP_SUB) || (op_e == OP_SBB) || (op_e == OP_CMP) || (op_e == OP_DEC);
    ax      = on_opnd ? opnd : acc_in;
    ay      = on_opnd ? '0   : opnd;
    acin    = on_opnd ? 1'b1 : (use_cin & flags_in[FC]);
  end

  alu_addsub #(.DW(DW)) u_addsub (
    .x(ax), .y(ay), .cin(acin), .sub(is_sub),
    .sum(asum), .cout(acout), .hcout(ahc)
  );

  logic [1:0]    rmode;
  logic [DW-1:0] rot_res, daa_res;
  logic          rot_c, daa_c, daa_ac;

  always_comb begin
    unique case (op_e)
      OP_RRC:  rmode = 2'd1;
      OP_RAL:  rmode = 2'd2;
      OP_RAR:  rmode = 2'd3;
      default: rmode = 2'd0;
    endcase
  end

  alu_rotdaa #(.DW(DW)) u_rotdaa (
    .a(acc_in), .cin(flags_in[FC]), .acin(flags_in[FA]), .rmode(rmode),
    .rot_res(rot_res), .rot_c(rot_c),
    .daa_res(daa_res), .daa_c(daa_c), .daa_ac(daa_ac)
  );

  // result and flag selection
  logic [DW-1:0]  nres, zsp_src;
  logic [FLW-1:0] nflg;
  logic           upd_zsp;

  always_comb begin
    nres    = acc_in;
    nflg    = flags_in;
    upd_zsp = 1'b0;
    zsp_src = asum;
    case (op_e)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        nres = asum; nflg[FC] = acout; nflg[FA] = ahc; upd_zsp = 1'b1;
      end
      OP_CMP: begin
        nflg[FC] = acout; nflg[FA] = ahc; upd_zsp = 1'b1;
      end
      OP_INC, OP_DEC: begin
        nres = asum; nflg[FA] = ahc; upd_zsp = 1'b1;
      end
      OP_AND: begin
        nres = acc_in & opnd; nflg[FC] = 1'b0;
        nflg[FA] = acc_in[NW-1] | opnd[NW-1];
        zsp_src = nres; upd_zsp = 1'b1;
      end
      OP_XOR, OP_OR: begin
        nres = (op_e == OP_XOR) ? (acc_in ^ opnd) : (acc_in | opnd);
        nflg[FC] = 1'b0; nflg[FA] = 1'b0;
        zsp_src = nres; upd_zsp = 1'b1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        nres = rot_res; nflg[FC] = rot_c;
      end
      OP_CMA: nres = ~acc_in;
      OP_CMC: nflg[FC] = ~flags_in[FC];
      OP_STC: nflg[FC] = 1'b1;
      OP_DAA: begin
        nres = daa_res; nflg[FC] = daa_c; nflg[FA] = daa_ac;
        zsp_src = daa_res; upd_zsp = 1'b1;
      end
      default: ;
    endcase
    if (upd_zsp) begin
      nflg[FZ] = (zsp_src == '0);
      nflg[FS] = zsp_src[DW-1];
      nflg[FP] = ~(^zsp_src);
    end
  end

  // output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      flags_out <= '0;
      res_vld   <= 1'b0;
    end else begin
      res_vld <= en;
      if (en) begin
        res_out   <= nres;
        flags_out <= nflg;
      end
    end
  end

  // assertions
  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(res_out) && $stable(flags_out) && !res_vld));

  p_incdec_keep_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (en && (op == 5'd8 || op == 5'd9)) |=> (flags_out[FC] == $past(flags_in[FC])));

  p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (rst)
    (en && op == 5'd7) |=> (res_out == $past(acc_in)));

  p_rotate_only_carry_r10: assert property (@(posedge clk) disable iff (rst)
    (en && op >= 5'd10 && op <= 5'd13) |=> (flags_out[FLW-1:1] == $past(flags_in[FLW-1:1])));

  p_set_carry_r11: assert property (@(posedge clk) disable iff (rst)
    (en && op == 5'd16) |=> flags_out[FC]);

  p_xor_or_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (en && (op == 5'd5 || op == 5'd6)) |=> (!flags_out[FC] && !flags_out[FA]));

  p_unused_passthru_r13: assert property (@(posedge clk) disable iff (rst)
    (en && op >= 5'd18) |=> (res_out == $past(acc_in) && flags_out == $past(flags_in)));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [4:0] op  = '0;
  logic [7:0] acc_in = '0, opnd = '0;
  logic [4:0] flags_in = '0;
  logic [7:0] res_out;
  logic [4:0] flags_out;
  logic       res_vld;

  int nchk = 0;
  int nerr = 0;
  logic [12:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst(rst), .en(en), .op(op), .acc_in(acc_in), .opnd(opnd),
    .flags_in(flags_in), .res_out(res_out), .flags_out(flags_out), .res_vld(res_vld)
  );

  // reference model from the requirements; flags {S,Z,AC,P,C}
  function automatic logic [12:0] ref_model(input logic [4:0] o, input logic [7:0] a,
                                            input logic [7:0] b, input logic [4:0] f);
    int ai, bi, ci, t;
    logic [7:0] r, zs;
    logic [4:0] nf;
    logic upd;
    ai = int'(a); bi = int'(b); ci = int'(f[0]);
    r = a; nf = f; upd = 1'b0; zs = a;
    case (o)
      5'd0, 5'd1: begin
        if (o == 5'd0) ci = 0;
        t = ai + bi + ci; r = 8'(t); zs = r; upd = 1'b1;
        nf[0] = (t > 255); nf[2] = ((ai % 16) + (bi % 16) + ci) > 15;
      end
      5'd2, 5'd3, 5'd7: begin
        if (o != 5'd3) ci = 0;
        t = ai - bi - ci; zs = 8'(t); upd = 1'b1;
        r = (o == 5'd7) ? a : zs;
        nf[0] = (t < 0); nf[2] = ((ai % 16) - (bi % 16) - ci) < 0;
      end
      5'd4: begin r = a & b; zs = r; upd = 1'b1; nf[0] = 1'b0; nf[2] = a[3] | b[3]; end
      5'd5: begin r = a ^ b; zs = r; upd = 1'b1; nf[0] = 1'b0; nf[2] = 1'b0; end
      5'd6: begin r = a | b; zs = r; upd = 1'b1; nf[0] = 1'b0; nf[2] = 1'b0; end
      5'd8: begin r = 8'(bi + 1); zs = r; upd = 1'b1; nf[2] = (bi % 16) == 15; end
      5'd9: begin r = 8'(bi - 1); zs = r; upd = 1'b1; nf[2] = (bi % 16) == 0; end
      5'd10: begin r = {a[6:0], a[7]}; nf[0] = a[7]; end
      5'd11: begin r = {a[0], a[7:1]}; nf[0] = a[0]; end
      5'd12: begin r = {a[6:0], f[0]}; nf[0] = a[7]; end
      5'd13: begin r = {f[0], a[7:1]}; nf[0] = a[0]; end
      5'd14: r = ~a;
      5'd15: nf[0] = ~f[0];
      5'd16: nf[0] = 1'b1;
      5'd17: begin
        t = ai;
        if ((ai % 16) > 9 || f[2]) begin
          nf[2] = ((ai % 16) + 6) > 15; t = t + 6;
        end else nf[2] = 1'b0;
        if ((t / 16) > 9 || f[0]) begin nf[0] = 1'b1; t = t + 96; end
        else nf[0] = 1'b0;
        r = 8'(t); zs = r; upd = 1'b1;
      end
      default: ;
    endcase
    if (upd) begin
      nf[3] = (zs == 8'h00);
      nf[4] = zs[7];
      nf[1] = ($countones(zs) % 2) == 0;
    end
    return {r, nf};
  endfunction

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: res/flags actual %h/%b expected %h/%b",
               tag, act[12:5], act[4:0], exp[12:5], exp[4:0]);
    end
  endtask

  task automatic issue(input string tag, input logic [4:0] o, input logic [7:0] a,
                       input logic [7:0] b, input logic [4:0] f);
    @(negedge clk);
    op = o; acc_in = a; opnd = b; flags_in = f; en = 1'b1;
    q_exp.push_back(ref_model(o, a, b, f));
    q_tag.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    en = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      if (q_exp.size() == 0) begin
        nchk++; nerr++;
        $display("FAIL R2: unexpected res_vld, actual 1 expected 0");
      end else begin
        check(q_tag.pop_front(), {res_out, flags_out}, q_exp.pop_front());
      end
    end
  end

  initial begin : watchdog
    #2000000;
    nerr++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  localparam logic [7:0] PATS [8] = '{8'h00, 8'h01, 8'h0F, 8'h7F, 8'h80, 8'h99, 8'hA5, 8'hFF};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", {res_out, flags_out}, 13'h0);
    nchk++; if (res_vld !== 1'b0) begin nerr++; $display("FAIL R1: res_vld actual %b expected 0", res_vld); end
    rst = 1'b0;

    // R3 add / add with carry
    issue("R3", 5'd0, 8'h3A, 8'hC6, 5'b00000);
    issue("R3", 5'd1, 8'hFF, 8'h00, 5'b00001);
    issue("R3", 5'd1, 8'h12, 8'h34, 5'b00000);
    // R4 subtract / borrow
    issue("R4", 5'd2, 8'h10, 8'h01, 5'b00000);
    issue("R4", 5'd3, 8'h00, 8'h00, 5'b00001);
    issue("R4", 5'd2, 8'h55, 8'h55, 5'b00001);
    // R5 compare
    issue("R5", 5'd7, 8'h05, 8'h09, 5'b00000);
    issue("R5", 5'd7, 8'h42, 8'h42, 5'b00001);
    // R6 inc/dec keep carry
    issue("R6", 5'd8, 8'h00, 8'hFF, 5'b00001);
    issue("R6", 5'd9, 8'h00, 8'h00, 5'b00000);
    issue("R6", 5'd8, 8'h00, 8'h0F, 5'b00000);
    issue("R6", 5'd9, 8'h00, 8'h01, 5'b00001);
    // R7 AND
    issue("R7", 5'd4, 8'h08, 8'h10, 5'b00001);
    issue("R7", 5'd4, 8'hF0, 8'h0F, 5'b00101);
    // R8 XOR / OR
    issue("R8", 5'd5, 8'hAA, 8'hAA, 5'b00101);
    issue("R8", 5'd6, 8'h00, 8'h00, 5'b00101);
    issue("R8", 5'd6, 8'h81, 8'h02, 5'b00000);
    // R10 rotates, other flags preset to check they are kept
    issue("R10", 5'd10, 8'h81, 8'h00, 5'b11110);
    issue("R10", 5'd11, 8'h01, 8'h00, 5'b01010);
    issue("R10", 5'd12, 8'h80, 8'h00, 5'b10100);
    issue("R10", 5'd13, 8'h01, 8'h00, 5'b00001);
    // R11 complement / carry ops
    issue("R11", 5'd14, 8'h5A, 8'h00, 5'b11111);
    issue("R11", 5'd15, 8'h33, 8'h00, 5'b10101);
    issue("R11", 5'd16, 8'h33, 8'h00, 5'b01010);
    // R12 decimal adjust, incl. both corrections in one op
    issue("R12", 5'd17, 8'h9B, 8'h00, 5'b00000);
    issue("R12", 5'd17, 8'h15, 8'h00, 5'b00100);
    issue("R12", 5'd17, 8'h99, 8'h00, 5'b00000);
    issue("R12", 5'd17, 8'h00, 8'h00, 5'b00001);
    issue("R12", 5'd17, 8'hFA, 8'h00, 5'b00000);
    // R13 unassigned codes
    issue("R13", 5'd25, 8'hC3, 8'h11, 5'b10110);
    issue("R13", 5'd31, 8'h00, 8'hFF, 5'b01001);
    // R9 sweep of every code over edge patterns
    for (int o = 0; o < 18; o++) begin
      for (int i = 0; i < 8; i++) begin
        issue("R9", 5'(o), PATS[i], PATS[7 - i], 5'(i * 3));
      end
    end
    idle();

    // R2 hold while enable low
    issue("R2", 5'd0, 8'h01, 8'h02, 5'b00000);
    @(negedge clk);
    en = 1'b0; op = 5'd14; acc_in = 8'hEE; opnd = 8'h77; flags_in = 5'b11111;
    repeat (3) @(negedge clk);
    check("R2", {res_out, flags_out}, ref_model(5'd0, 8'h01, 8'h02, 5'b00000));
    nchk++; if (res_vld !== 1'b0) begin nerr++; $display("FAIL R2: res_vld actual %b expected 0", res_vld); end

    repeat (2) @(negedge clk);
    nchk++;
    if (q_exp.size() != 0) begin
      nerr++;
      $display("FAIL R2: results missing, actual %0d pending expected 0", q_exp.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule